// File: doc/BRIEF.md
# Strobed Consecutive-Sample Input Filter with Edge Pulses

This block conditions a group of asynchronous digital inputs before they reach edge-triggered logic. Every input first passes through a two-flop synchronizer. A shared divider produces a sample strobe once every four system clocks. Each channel compares its synchronized level with its current filtered level on every strobe. The filtered level takes the new value only after three strobes in a row have captured that new value. A shorter excursion is treated as noise and leaves the filtered level unchanged.

When a channel's filtered level changes, the channel produces a one-clock pulse on its rising or falling output. Two per-channel enable bits decide which polarities are reported. A separate output carries the synchronized but unfiltered pin levels, so software can read the pins as they are.

Noise that happens to line up with the strobe can still pass the filter, and this is accepted. The window is bounded: a pin level held for eight clocks or fewer is never accepted, and a level held for twelve clocks or more is always accepted.

Top module: `sampled_edge_filter`

## Requirements
- R1: The sample strobe is high for one clock in every DIV clocks (DIV = 4). The first strobe falls in the fourth clock after reset is released.
- R2: A channel's filtered level changes only in the clock after a strobe. That strobe must be the NMATCH-th consecutive strobe (NMATCH = 3) on which the synchronized input differed from the filtered level.
- R3: A pin level held for 8 clocks or fewer never changes the filtered level and produces no edge pulse. This covers a level seen on only two strobes before it reverts.
- R4: A filtered change from 0 to 1 gives a pulse on `rise_o` for that channel, and a change from 1 to 0 gives a pulse on `fall_o`. Each pulse lasts one clock and appears in the same clock as the new filtered level. The two outputs are never high together on one channel.
- R5: A pin level held for 12 clocks or more is always accepted, whatever the strobe phase. The edge pulse appears between 10 and 13 clock edges after the edge that first captures the new pin level.
- R6: A pulse on `rise_o[i]` or `fall_o[i]` appears only if `rise_en_i[i]` or `fall_en_i[i]`, respectively, was 1 at the edge that registered it. `filt_o` tracks the input whatever the enable bits are.
- R7: `raw_o` equals `pin_i` delayed by two clocks, with no filtering.
- R8: While reset (`rst_n` low, synchronous) is held, the edge outputs are 0 and each filtered level is loaded from its synchronized input. No edge pulse follows the release of reset.
- R9: The channels are independent: activity on one pin never changes another channel's filtered level or edge outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NCH (6) | Asynchronous input pins |
| rise_en_i | input | NCH | Per-channel rising-edge report enable |
| fall_en_i | input | NCH | Per-channel falling-edge report enable |
| raw_o | output | NCH | Synchronized unfiltered pin levels |
| filt_o | output | NCH | Filtered levels |
| rise_o | output | NCH | One-clock rising-edge pulses |
| fall_o | output | NCH | One-clock falling-edge pulses |

## Verification
The checker watches the following on every cycle:
- the strobe spacing;
- that a filtered level moves only after an accepted strobe;
- that each pulse agrees with the filtered transition and with its enable bit;
- that the two polarities never coincide on one channel;
- the two-clock raw path.

Only the bench scenarios can show the outcomes that depend on a window:
- glitches of seven and eight clocks at every strobe phase are rejected;
- twelve-clock pulses at every phase are accepted;
- the 10-to-13-clock latency holds;
- no pulse follows reset.

A behavioural model compared on every clock covers the channel independence.

// File: rtl/sef_pkg.sv
package sef_pkg;

  // Phase counter advance, wrapping at the divide ratio.
  function automatic int unsigned phase_next(int unsigned ph, int unsigned div);
    return (ph + 1 >= div) ? 0 : ph + 1;
  endfunction

  // Strobe is asserted in the last phase of each divide period.
  function automatic logic phase_is_strobe(int unsigned ph, int unsigned div);
    return (ph == div - 1);
  endfunction

  // True when one more differing sample completes the required run.
  function automatic logic run_complete(int unsigned run, int unsigned nmatch);
    return (run + 1 >= nmatch);
  endfunction

endpackage

// File: rtl/sef_strobe_gen.sv
module sef_strobe_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe_o
);
  import sef_pkg::*;

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= CW'(phase_next(int'(phase_q), DIV));
    end
  end

  assign strobe_o = phase_is_strobe(int'(phase_q), DIV);

endmodule

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sef_chan.sv
module sef_chan #(
  parameter int unsigned NMATCH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic lvl_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic filt_o,
  output logic rise_o,
  output logic fall_o,
  output logic accept_o
);
  import sef_pkg::*;

  localparam int unsigned RW = $clog2(NMATCH + 1);

  logic [RW-1:0] run_q;
  logic          filt_q;
  logic          rise_q;
  logic          fall_q;
  logic          differ;

  assign differ   = (lvl_i != filt_q);
  assign accept_o = strobe_i && differ && run_complete(int'(run_q), NMATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= lvl_i;
      run_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= accept_o && lvl_i && rise_en_i;
      fall_q <= accept_o && !lvl_i && fall_en_i;
      if (strobe_i) begin
        if (!differ) begin
          run_q <= '0;
        end else if (accept_o) begin
          filt_q <= lvl_i;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign filt_o = filt_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/sampled_edge_filter.sv
module sampled_edge_filter #(
  parameter int unsigned NCH    = 6,
  parameter int unsigned DIV    = 4,
  parameter int unsigned NMATCH = 3,
  parameter int unsigned SYNC   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] rise_en_i,
  input  logic [NCH-1:0] fall_en_i,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] filt_o,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  logic           strobe_w;
  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] accept_w;

  sef_strobe_gen #(.DIV(DIV)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_o (strobe_w)
  );

  sef_sync #(.W(NCH), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .d_i (pin_i),
    .q_o (sync_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sef_chan #(.NMATCH(NMATCH)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_i  (strobe_w),
      .lvl_i     (sync_w[c]),
      .rise_en_i (rise_en_i[c]),
      .fall_en_i (fall_en_i[c]),
      .filt_o    (filt_o[c]),
      .rise_o    (rise_o[c]),
      .fall_o    (fall_o[c]),
      .accept_o  (accept_w[c])
    );
  end

  assign raw_o = sync_w;

endmodule

// File: rtl/sef_checker.sv
module sef_checker #(
  parameter int unsigned NCH = 6,
  parameter int unsigned DIV = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pin_i,
  input logic [NCH-1:0] rise_en_i,
  input logic [NCH-1:0] fall_en_i,
  input logic [NCH-1:0] raw_o,
  input logic [NCH-1:0] filt_o,
  input logic [NCH-1:0] rise_o,
  input logic [NCH-1:0] fall_o,
  input logic           strobe_i,
  input logic [NCH-1:0] accept_i
);
  localparam int unsigned GW = $clog2(DIV + 1);

  logic [GW-1:0] gap_q;
  logic [1:0]    age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      age_q <= '0;
    end else begin
      gap_q <= strobe_i ? '0 : gap_q + 1'b1;
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end
  end

  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |-> gap_q == GW'(DIV - 1)); // R1
  AST_STROBE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q == GW'(DIV - 1) |-> strobe_i); // R1
  AST_FILT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && filt_o != $past(filt_o)) |-> $past(strobe_i) && ($past(accept_i) != '0)); // R2
  AST_ACCEPT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i != '0) |=> ((filt_o ^ $past(filt_o)) == $past(accept_i))); // R2
  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (rise_o & ~(filt_o & ~$past(filt_o))) == '0); // R4
  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (fall_o & ~(~filt_o & $past(filt_o))) == '0); // R4
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & fall_o) == '0); // R4
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> ((rise_o & ~$past(rise_en_i)) | (fall_o & ~$past(fall_en_i))) == '0); // R6
  AST_RAW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> raw_o == $past(pin_i, 2)); // R7
  AST_NO_EDGE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (rise_o | fall_o) == '0); // R8

endmodule

bind sampled_edge_filter sef_checker #(.NCH(NCH), .DIV(DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_i     (pin_i),
  .rise_en_i (rise_en_i),
  .fall_en_i (fall_en_i),
  .raw_o     (raw_o),
  .filt_o    (filt_o),
  .rise_o    (rise_o),
  .fall_o    (fall_o),
  .strobe_i  (strobe_w),
  .accept_i  (accept_w)
);

// File: tb/sim_sampled_edge_filter.sv
`timescale 1ns/1ps
module sim_sampled_edge_filter;
  localparam int N = 6;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [N-1:0] pins = '0;
  logic [N-1:0] ren = '1;
  logic [N-1:0] fen = '1;
  logic [N-1:0] raw, filt, rise, fall;

  int n_chk = 0;
  int n_fail = 0;
  int rise_cnt [N];
  int fall_cnt [N];

  always #4 clk = ~clk;

  sampled_edge_filter u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .rise_en_i(ren), .fall_en_i(fen),
    .raw_o(raw), .filt_o(filt), .rise_o(rise), .fall_o(fall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference: delay line, phase integer, run integers.
  int           ph = 0;
  bit           s1 [N], s2 [N], mf [N], mr [N], mfl [N];
  int           run [N];
  bit           st;
  logic [N-1:0] m_raw, m_filt, m_rise, m_fall;

  always @(posedge clk) begin
    st = (ph == 3);
    for (int c = 0; c < N; c++) begin
      if (!rst_n) begin
        mf[c] = s2[c]; run[c] = 0; mr[c] = 0; mfl[c] = 0;
      end else begin
        mr[c] = 0; mfl[c] = 0;
        if (st) begin
          if (s2[c] != mf[c]) begin
            run[c]++;
            if (run[c] == 3) begin
              mf[c] = s2[c]; run[c] = 0;
              if (mf[c]) mr[c] = ren[c]; else mfl[c] = fen[c];
            end
          end else run[c] = 0;
        end
      end
      s2[c] = s1[c];
      s1[c] = pins[c];
    end
    ph = (!rst_n) ? 0 : (ph + 1) % 4;
  end

  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      m_raw[c] = s2[c]; m_filt[c] = mf[c]; m_rise[c] = mr[c]; m_fall[c] = mfl[c];
    end
    if (rst_n) begin
      chk(raw == m_raw, "R7 raw path", raw, m_raw);
      chk(filt == m_filt, "R2/R9 filtered level", filt, m_filt);
      chk(rise == m_rise, "R4/R6 rise pulse", rise, m_rise);
      chk(fall == m_fall, "R4/R6 fall pulse", fall, m_fall);
      for (int c = 0; c < N; c++) begin
        if (rise[c]) rise_cnt[c]++;
        if (fall[c]) fall_cnt[c]++;
      end
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int width);
    @(negedge clk); pins[ch] = 1'b1;
    clocks(width);
    pins[ch] = 1'b0;
    clocks(24);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r0, f0, lat;
    // R8: reset state with a mixed pin pattern.
    pins = 6'b101010;
    clocks(6);
    chk(rise == '0 && fall == '0, "R8 pulses in reset", {rise, fall}, 0);
    chk(filt == 6'b101010, "R8 filt loaded in reset", filt, 6'b101010);
    rst_n = 1;
    clocks(20);
    chk(rise_cnt[1] + rise_cnt[3] + rise_cnt[5] == 0, "R8 no edge after release",
        rise_cnt[1] + rise_cnt[3] + rise_cnt[5], 0);
    pins = '0;
    clocks(24);

    // R5: latency at every strobe phase.
    for (int p = 0; p < 4; p++) begin
      clocks(p + 1);
      pins[0] = 1'b1;
      lat = 0;
      do begin
        @(posedge clk); lat++;
        @(negedge clk);
      end while (!rise[0] && lat < 40);
      chk(lat - 1 >= 10 && lat - 1 <= 13, "R5 latency", lat - 1, 10);
      pins[0] = 1'b0;
      clocks(24);
    end

    // R3: 7- and 8-clock glitches at every phase.
    r0 = rise_cnt[1];
    for (int p = 0; p < 4; p++) begin
      clocks(p); pulse(1, 7);
      clocks(p); pulse(1, 8);
    end
    chk(rise_cnt[1] == r0, "R3 short glitch rejected", rise_cnt[1] - r0, 0);
    chk(filt[1] == 1'b0, "R3 filt unchanged", filt[1], 0);

    // R5: 12-clock pulses at every phase.
    r0 = rise_cnt[2]; f0 = fall_cnt[2];
    for (int p = 0; p < 4; p++) begin
      clocks(p); pulse(2, 12);
    end
    chk(rise_cnt[2] - r0 == 4, "R5 12-clock rise accepted", rise_cnt[2] - r0, 4);
    chk(fall_cnt[2] - f0 == 4, "R5 12-clock fall accepted", fall_cnt[2] - f0, 4);

    // R6: rise disabled, fall enabled on channel 3.
    ren[3] = 1'b0;
    r0 = rise_cnt[3]; f0 = fall_cnt[3];
    @(negedge clk); pins[3] = 1'b1;
    clocks(24);
    chk(filt[3] == 1'b1, "R6 filt tracks when disabled", filt[3], 1);
    chk(rise_cnt[3] == r0, "R6 rise suppressed", rise_cnt[3] - r0, 0);
    pins[3] = 1'b0;
    clocks(24);
    chk(fall_cnt[3] - f0 == 1, "R6 fall reported", fall_cnt[3] - f0, 1);
    ren[3] = 1'b1;
    fen[3] = 1'b0;
    f0 = fall_cnt[3];
    pulse(3, 16);
    chk(fall_cnt[3] == f0, "R6 fall suppressed", fall_cnt[3] - f0, 0);
    fen[3] = 1'b1;

    // R7: raw path follows a fast toggle unfiltered.
    @(negedge clk); pins[5] = 1'b1;
    clocks(2);
    chk(raw[5] == 1'b1, "R7 raw after two clocks", raw[5], 1);
    chk(filt[5] == 1'b0, "R7 filt not yet changed", filt[5], 0);
    pins[5] = 1'b0;
    clocks(24);

    // R9: channel 4 activity leaves others untouched.
    r0 = rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] + rise_cnt[5];
    pulse(4, 20);
    chk(rise_cnt[4] >= 1, "R9 channel 4 edge", rise_cnt[4], 1);
    chk(rise_cnt[0] + rise_cnt[1] + rise_cnt[2] + rise_cnt[3] + rise_cnt[5] == r0,
        "R9 other channels quiet", 0, 0);

    // R1/R2/R4: pattern across all channels together.
    @(negedge clk); pins = 6'b110011;
    clocks(30);
    chk(filt == 6'b110011, "R2 filt follows held pattern", filt, 6'b110011);
    pins = 6'b011110;
    clocks(30);
    chk(filt == 6'b011110, "R4 mixed edges settled", filt, 6'b011110);

    finish_run();
  end
endmodule